// File: doc/BRIEF.md
# Four-level translation table walker

This block converts a 64-bit linear address into a 52-bit physical address. It reads one entry from each of four nested in-memory tables. A request carries the linear address, a write flag, an execute flag and the current privilege level. The base of the top table comes from a 64-bit control register. The block reads each entry over a single-outstanding request/response memory port. It uses the entry to locate the next table, and uses the entry at the lowest level to locate the page frame.

Before it touches memory, the walker checks that the address is canonical. During the walk it stops at the first entry whose present bit is clear. It collects the user, write and no-execute attributes across all four levels and judges them once the last entry arrives. A result is a one-cycle pulse that carries either the physical address or a fault cause. The request side accepts a new request only while the walker is idle.

Top module: `xlat_walk4`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, while `done_valid` and `mem_rd_valid` are 0.
- R2: Each entry read address is {table base, 9-bit index, 3'b000}. The walk reads four entries in this order, taking the index from linear address bits 47:39, then 38:30, then 29:21, then 20:12. The first table base is bits 51:12 of `root_reg`, and bits 63:52 and 11:0 of that register have no effect. Each later table base is bits 51:12 of the entry just read.
- R3: An address whose bits 63:48 are not all equal to bit 47 gives fault code 1 in the cycle after acceptance, and no memory read is issued for it.
- R4: If an entry has bit 0 (present) clear, the walk ends with fault code 2 and no further entry is read.
- R5: A walk without a fault reports code 0 and the physical address {last entry bits 51:12, linear address bits 11:0}.
- R6: A user access (privilege level 3) needs bit 2 set in all four entries, otherwise it faults with code 3. Privilege levels 0 to 2 ignore bit 2.
- R7: A user write needs bit 1 set in all four entries, otherwise it faults with code 4. Supervisor writes ignore bit 1.
- R8: An execute access faults with code 5 if bit 63 is set in any of the four entries. Accesses that do not execute ignore bit 63.
- R9: When more than one permission fault applies, code 3 takes priority over code 4, and code 4 takes priority over code 5.
- R10: `req_ready` is 0 from acceptance until the result pulse, including the pulse cycle. Each accepted request yields exactly one `done_valid` pulse. A faulting result reports `done_paddr` as 0.
- R11: Only one entry read is outstanding at a time. `mem_rd_valid` is a one-cycle pulse, and the next read starts only after the response arrives, however long the response takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, accepts a request |
| req_vaddr | input | 64 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_exec | input | 1 | Access is an instruction fetch |
| req_cpl | input | 2 | Current privilege level (3 = user) |
| root_reg | input | 64 | Control register holding the top table base in bits 51:12 |
| mem_rd_valid | output | 1 | Entry read request pulse |
| mem_rd_addr | output | 52 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 64 | Entry contents |
| done_valid | output | 1 | Result pulse |
| done_paddr | output | 52 | Translated physical address (0 on fault) |
| done_fault | output | 3 | Fault cause: 0 none, 1 non-canonical, 2 not-present, 3 user, 4 write, 5 execute |

## Verification
The assertions assume that the memory returns exactly one `mem_rsp_valid` pulse per read. They assume it never answers in the same cycle as the read pulse, and never answers while no read is pending. They also assume that `req_vaddr`, `root_reg` and the request attributes hold steady only in the cycle of acceptance. The bench memory model keeps to these rules: it answers each read after 0 to 3 extra idle cycles, and it returns zero for any entry that was never written. Requests are presented only while the bench has no walk in flight.

// File: rtl/xlat_walk_pkg.sv
package xlat_walk_pkg;

   typedef enum logic [2:0] {
      FLT_NONE    = 3'd0,
      FLT_CANON   = 3'd1,
      FLT_NOTPRES = 3'd2,
      FLT_USER    = 3'd3,
      FLT_WRITE   = 3'd4,
      FLT_EXEC    = 3'd5
   } flt_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT,
      ST_DONE
   } walk_st_e;

   localparam int ENT_W  = 64;
   localparam int P_BIT  = 0;
   localparam int RW_BIT = 1;
   localparam int US_BIT = 2;
   localparam int NX_BIT = 63;

endpackage

// File: rtl/xlat_canon_chk.sv
module xlat_canon_chk #(
   parameter int VA_W  = 64,
   parameter int SIG_W = 48
) (
   input  logic [VA_W-1:0] va,
   output logic            ok
);

   generate
      if (SIG_W >= VA_W) begin : g_full
         logic unused_va;
         assign unused_va = ^va;
         assign ok = 1'b1;
      end else begin : g_sext
         // upper bits together with the top significant bit must be uniform
         assign ok = (&va[VA_W-1:SIG_W-1]) | ~(|va[VA_W-1:SIG_W-1]);
      end
   endgenerate

endmodule

// File: rtl/xlat_idx_sel.sv
module xlat_idx_sel #(
   parameter int LEVELS = 4,
   parameter int IDX_W  = 9,
   parameter int OFS_W  = 12,
   parameter int LVL_W  = 2
) (
   input  logic [LEVELS*IDX_W+OFS_W-1:0] va,
   input  logic [LVL_W-1:0]              lvl,
   output logic [IDX_W-1:0]              idx
);

   logic [IDX_W-1:0] slice [LEVELS];
   logic             unused_ofs;

   assign unused_ofs = ^va[OFS_W-1:0];

   generate
      for (genvar g = 0; g < LEVELS; g++) begin : g_slice
         assign slice[g] = va[OFS_W + g*IDX_W +: IDX_W];
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = 0; i < LEVELS; i++) begin
         if (lvl == LVL_W'(i)) idx = slice[i];
      end
   end

endmodule

// File: rtl/xlat_perm_acc.sv
module xlat_perm_acc #(
   parameter bit NX_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic load,
   input  logic ent_rw,
   input  logic ent_us,
   input  logic ent_nx,
   output logic rw_all,
   output logic us_all,
   output logic nx_any
);

   logic rw_q, us_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         rw_q <= 1'b1;
         us_q <= 1'b1;
      end else if (load) begin
         rw_q <= rw_q & ent_rw;
         us_q <= us_q & ent_us;
      end
   end

   // views include the entry currently on the response bus
   assign rw_all = rw_q & ent_rw;
   assign us_all = us_q & ent_us;

   generate
      if (NX_EN) begin : g_nx
         logic nx_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clear) nx_q <= 1'b0;
            else if (load)       nx_q <= nx_q | ent_nx;
         end
         assign nx_any = nx_q | ent_nx;

         // R8
         nx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (load && ent_nx && !clear) |=> nx_any);
      end else begin : g_no_nx
         logic unused_nx;
         assign unused_nx = ent_nx;
         assign nx_any    = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/xlat_walk4.sv
module xlat_walk4
   import xlat_walk_pkg::*;
#(
   parameter int VA_W   = 64,
   parameter int SIG_W  = 48,
   parameter int PA_W   = 52,
   parameter int LEVELS = 4,
   parameter int IDX_W  = 9,
   parameter int OFS_W  = 12,
   parameter bit NX_EN  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_vaddr,
   input  logic            req_write,
   input  logic            req_exec,
   input  logic [1:0]      req_cpl,
   input  logic [63:0]     root_reg,
   output logic            mem_rd_valid,
   output logic [PA_W-1:0] mem_rd_addr,
   input  logic            mem_rsp_valid,
   input  logic [ENT_W-1:0] mem_rsp_data,
   output logic            done_valid,
   output logic [PA_W-1:0] done_paddr,
   output logic [2:0]      done_fault
);

   localparam int FRAME_W = PA_W - OFS_W;
   localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1;
   localparam int ESZ_W   = OFS_W - IDX_W;

   generate
      if (SIG_W != LEVELS*IDX_W + OFS_W) begin : g_bad_split
         $error("index fields and offset must cover the significant address bits");
      end
      if (ESZ_W != 3) begin : g_bad_table
         $error("a table must hold 2**IDX_W entries of 8 bytes in one page");
      end
      if (PA_W >= NX_BIT || SIG_W > VA_W) begin : g_bad_width
         $error("physical width must stay below the no-execute bit");
      end
   endgenerate

   walk_st_e           st_q;
   flt_e               flt_q, fin_flt;
   logic [SIG_W-1:0]   va_q;
   logic               wr_q, ex_q, usr_q;
   logic [LVL_W-1:0]   lvl_q;
   logic [FRAME_W-1:0] base_q;
   logic [PA_W-1:0]    pa_q;
   logic               canon_ok;
   logic [IDX_W-1:0]   idx;
   logic               rw_all, us_all, nx_any;
   logic               accept, rsp_hit, ent_p;
   logic [FRAME_W-1:0] ent_frame;
   logic               unused_bits;

   assign unused_bits = ^{root_reg[63:PA_W], root_reg[OFS_W-1:0],
                          mem_rsp_data[NX_BIT-1:PA_W], mem_rsp_data[OFS_W-1:US_BIT+1]};

   assign accept    = (st_q == ST_IDLE) && req_valid;
   assign rsp_hit   = (st_q == ST_WAIT) && mem_rsp_valid;
   assign ent_p     = mem_rsp_data[P_BIT];
   assign ent_frame = mem_rsp_data[PA_W-1:OFS_W];

   xlat_canon_chk #(.VA_W(VA_W), .SIG_W(SIG_W)) u_canon (
      .va (req_vaddr),
      .ok (canon_ok)
   );

   xlat_idx_sel #(.LEVELS(LEVELS), .IDX_W(IDX_W), .OFS_W(OFS_W), .LVL_W(LVL_W)) u_idx (
      .va  (va_q),
      .lvl (lvl_q),
      .idx (idx)
   );

   xlat_perm_acc #(.NX_EN(NX_EN)) u_perm (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (accept),
      .load   (rsp_hit && ent_p),
      .ent_rw (mem_rsp_data[RW_BIT]),
      .ent_us (mem_rsp_data[US_BIT]),
      .ent_nx (mem_rsp_data[NX_BIT]),
      .rw_all (rw_all),
      .us_all (us_all),
      .nx_any (nx_any)
   );

   // permission verdict on the last level, fixed priority user > write > execute
   always_comb begin
      if (usr_q && !us_all)                fin_flt = FLT_USER;
      else if (usr_q && wr_q && !rw_all)   fin_flt = FLT_WRITE;
      else if (ex_q && nx_any)             fin_flt = FLT_EXEC;
      else                                 fin_flt = FLT_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         flt_q  <= FLT_NONE;
         va_q   <= '0;
         wr_q   <= 1'b0;
         ex_q   <= 1'b0;
         usr_q  <= 1'b0;
         lvl_q  <= '0;
         base_q <= '0;
         pa_q   <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (req_valid) begin
               va_q   <= req_vaddr[SIG_W-1:0];
               wr_q   <= req_write;
               ex_q   <= req_exec;
               usr_q  <= (req_cpl == 2'd3);
               lvl_q  <= LVL_W'(LEVELS-1);
               base_q <= root_reg[PA_W-1:OFS_W];
               pa_q   <= '0;
               if (!canon_ok) begin
                  flt_q <= FLT_CANON;
                  st_q  <= ST_DONE;
               end else begin
                  flt_q <= FLT_NONE;
                  st_q  <= ST_ISSUE;
               end
            end
            ST_ISSUE: st_q <= ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) begin
               if (!ent_p) begin
                  flt_q <= FLT_NOTPRES;
                  pa_q  <= '0;
                  st_q  <= ST_DONE;
               end else if (lvl_q == '0) begin
                  flt_q <= fin_flt;
                  pa_q  <= (fin_flt == FLT_NONE) ? {ent_frame, va_q[OFS_W-1:0]} : '0;
                  st_q  <= ST_DONE;
               end else begin
                  base_q <= ent_frame;
                  lvl_q  <= lvl_q - 1'b1;
                  st_q   <= ST_ISSUE;
               end
            end
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready    = (st_q == ST_IDLE);
   assign mem_rd_valid = (st_q == ST_ISSUE);
   assign mem_rd_addr  = {base_q, idx, {ESZ_W{1'b0}}};
   assign done_valid   = (st_q == ST_DONE);
   assign done_paddr   = pa_q;
   assign done_fault   = flt_q;

   // R10
   busy_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> !req_ready);

   // R3
   canon_flt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !canon_ok) |=> (done_valid && done_fault == 3'(FLT_CANON)));

   // R4
   notpres_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_hit && !mem_rsp_data[P_BIT]) |=> (done_valid && done_fault == 3'(FLT_NOTPRES)));

   // R10
   flt_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && done_fault != 3'(FLT_NONE)) |-> (done_paddr == '0));

   // R11
   single_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |=> !mem_rd_valid);

   // R5
   page_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && done_fault == 3'(FLT_NONE)) |-> (done_paddr[OFS_W-1:0] == va_q[OFS_W-1:0]));

endmodule

// File: tb/xlat_walk4_bench.sv
module xlat_walk4_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        req_exec = 1'b0;
   logic [1:0]  req_cpl = 2'd0;
   logic [63:0] root_reg = '0;
   logic        mem_rd_valid;
   logic [51:0] mem_rd_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        done_valid;
   logic [51:0] done_paddr;
   logic [2:0]  done_fault;

   always #(CLK_PERIOD/2) clk = ~clk;

   xlat_walk4 u_xlat_walk4 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_write(req_write), .req_exec(req_exec), .req_cpl(req_cpl),
      .root_reg(root_reg),
      .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done_valid(done_valid), .done_paddr(done_paddr), .done_fault(done_fault)
   );

   logic [63:0] mem [logic [51:0]];
   logic [51:0] exp_rd [$];
   logic [51:0] exp_pa;
   logic [2:0]  exp_flt;
   string       cur_tag = "R1";
   int          lat = 0;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          inflight = 1'b0;
   bit          pend = 1'b0;
   int          cnt = 0;
   logic [51:0] pend_addr;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   task automatic set_ent(input logic [39:0] frame, input logic [8:0] idx,
                          input logic [39:0] nxt, input logic [3:0] fl);
      mem[{frame, idx, 3'b000}] = {fl[3], 11'b0, nxt, 9'b0, fl[2:0]};
   endtask

   // fl holds {nx,us,rw,p} per level, level 3 (top) in bits 15:12
   task automatic map(input logic [63:0] va, input logic [39:0] root_fr,
                      input logic [39:0] f0, input logic [15:0] fl);
      logic [39:0] tbl;
      tbl = root_fr;
      for (int l = 3; l >= 0; l--) begin
         set_ent(tbl, va[12 + 9*l +: 9], f0 + 40'(3 - l), fl[4*l +: 4]);
         tbl = f0 + 40'(3 - l);
      end
   endtask

   // reference model taken from the requirements
   task automatic ref_walk(input logic [63:0] va, input bit wr, input bit ex,
                           input logic [1:0] cpl, input logic [63:0] root);
      logic [39:0] base;
      logic [51:0] a;
      logic [63:0] e;
      bit rw, us, nx, user;
      exp_rd.delete();
      exp_pa = '0;
      if (va[63:47] != '0 && va[63:47] != '1) begin
         exp_flt = 3'd1;
         return;
      end
      base = root[51:12];
      rw = 1; us = 1; nx = 0;
      for (int l = 3; l >= 0; l--) begin
         a = {base, va[12 + 9*l +: 9], 3'b000};
         exp_rd.push_back(a);
         e = mem.exists(a) ? mem[a] : 64'd0;
         if (!e[0]) begin
            exp_flt = 3'd2;
            return;
         end
         rw &= e[1]; us &= e[2]; nx |= e[63];
         base = e[51:12];
      end
      user = (cpl == 2'd3);
      if (user && !us)            exp_flt = 3'd3;
      else if (user && wr && !rw) exp_flt = 3'd4;
      else if (ex && nx)          exp_flt = 3'd5;
      else begin
         exp_flt = 3'd0;
         exp_pa  = {base, va[11:0]};
      end
   endtask

   task automatic run(input logic [63:0] va, input bit wr, input bit ex,
                      input logic [1:0] cpl, input logic [63:0] root,
                      input int lt, input string tag);
      ref_walk(va, wr, ex, cpl, root);
      @(negedge clk);
      cur_tag   = tag;
      lat       = lt;
      req_vaddr = va;
      req_write = wr;
      req_exec  = ex;
      req_cpl   = cpl;
      root_reg  = root;
      req_valid = 1'b1;
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      inflight  = 1'b1;
      wait (!inflight);
   endtask

   // memory model and per-clock comparison
   always @(negedge clk) begin
      if (rst_n) begin
         chk(req_ready == !inflight, "R10", "req_ready", 64'(req_ready), 64'(!inflight));
         mem_rsp_valid = 1'b0;
         if (pend) begin
            if (cnt == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = mem.exists(pend_addr) ? mem[pend_addr] : 64'd0;
               pend = 1'b0;
            end else begin
               cnt--;
            end
         end
         if (mem_rd_valid) begin
            if (exp_rd.size() == 0) begin
               chk(0, cur_tag, "unexpected entry read", 64'(mem_rd_addr), 64'd0);
            end else begin
               logic [51:0] ea;
               ea = exp_rd.pop_front();
               chk(mem_rd_addr == ea, "R2", "entry read address", 64'(mem_rd_addr), 64'(ea));
            end
            chk(!pend, "R11", "read while one outstanding", 64'(pend), 64'd0);
            pend      = 1'b1;
            pend_addr = mem_rd_addr;
            cnt       = lat;
         end
         if (done_valid) begin
            if (!inflight) begin
               chk(0, "R10", "result pulse without request", 64'(done_fault), 64'd0);
            end else begin
               chk(done_fault == exp_flt, cur_tag, "fault code", 64'(done_fault), 64'(exp_flt));
               chk(done_paddr == exp_pa, cur_tag, "physical address", 64'(done_paddr), 64'(exp_pa));
               chk(exp_rd.size() == 0, cur_tag, "entry reads missing", 64'(exp_rd.size()), 64'd0);
               inflight = 1'b0;
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired in %s actual=hung expected=done", cur_tag);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   localparam logic [63:0] ROOT = 64'h0000_0000_0010_0000;

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
      chk(done_valid == 1'b0, "R1", "done_valid", 64'(done_valid), 64'd0);
      chk(mem_rd_valid == 1'b0, "R1", "mem_rd_valid", 64'(mem_rd_valid), 64'd0);

      // R5 fully permissive user read
      map(64'h0000_1234_5678_9abc, 40'h100, 40'h200, 16'h7777);
      run(64'h0000_1234_5678_9abc, 0, 0, 2'd3, ROOT, 0, "R5");
      // R5 kernel address, R7 supervisor write ignores read/write bit
      map(64'hffff_ffff_8100_0123, 40'h100, 40'h300, 16'h1111);
      run(64'hffff_ffff_8100_0123, 0, 0, 2'd0, ROOT, 1, "R5");
      run(64'hffff_ffff_8100_0123, 1, 0, 2'd0, ROOT, 0, "R7");

      // R3 non-canonical addresses
      run(64'h0000_8000_0000_0000, 0, 0, 2'd0, ROOT, 0, "R3");
      run(64'hffff_0000_0000_0000, 0, 0, 2'd0, ROOT, 0, "R3");
      run(64'h1234_0000_0000_1000, 1, 1, 2'd3, ROOT, 0, "R3");

      // R4 not present at the top level and at the lowest level
      run(64'h0000_7000_0000_0000, 0, 0, 2'd0, ROOT, 0, "R4");
      map(64'h0000_0040_0020_1000, 40'h100, 40'h400, 16'h7777);
      set_ent(40'h402, 9'h001, 40'h0, 4'h0);
      run(64'h0000_0040_0020_1000, 0, 0, 2'd3, ROOT, 2, "R4");

      // R6 user bit clear at level 2
      map(64'h0000_0000_4000_0000, 40'h100, 40'h500, 16'h7377);
      run(64'h0000_0000_4000_0000, 0, 0, 2'd3, ROOT, 0, "R6");
      run(64'h0000_0000_4000_0000, 0, 0, 2'd0, ROOT, 0, "R6");

      // R7 read/write bit clear at the lowest level
      map(64'h0000_0001_0000_5000, 40'h100, 40'h600, 16'h7775);
      run(64'h0000_0001_0000_5000, 1, 0, 2'd3, ROOT, 0, "R7");
      run(64'h0000_0001_0000_5000, 0, 0, 2'd3, ROOT, 0, "R7");
      run(64'h0000_0001_0000_5000, 1, 0, 2'd1, ROOT, 0, "R7");

      // R8 no-execute set at level 1
      map(64'h0000_0002_0020_0000, 40'h100, 40'h700, 16'h77f7);
      run(64'h0000_0002_0020_0000, 0, 1, 2'd0, ROOT, 0, "R8");
      run(64'h0000_0002_0020_0000, 0, 0, 2'd3, ROOT, 0, "R8");

      // R9 priority among permission faults
      map(64'h0000_0003_0000_0000, 40'h100, 40'h800, 16'h9777);
      run(64'h0000_0003_0000_0000, 1, 1, 2'd3, ROOT, 0, "R9");
      map(64'h0000_0004_0000_0000, 40'h100, 40'h900, 16'h7d77);
      run(64'h0000_0004_0000_0000, 1, 1, 2'd3, ROOT, 0, "R9");

      // R2 junk in the ignored control register bits
      run(64'h0000_1234_5678_9abc, 0, 0, 2'd3, 64'habc0_0000_0010_0fff, 0, "R2");
      // R11 slow memory responses
      run(64'h0000_1234_5678_9abc, 1, 1, 2'd3, ROOT, 3, "R11");

      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule